// File: doc/BRIEF.md
# Metastability-Containing Gray Code Sorter

The block sorts two Gray-coded time-difference words into a larger and a smaller word. Every digit of each word is a trit: a stable 0, a stable 1, or an unresolved (metastable) value. It is meant for datapaths where a measured time difference may still be settling when it reaches logic, so the outputs are computed without first forcing any digit to resolve. Each output trit is settled only if it would come out the same whichever way the unresolved input trits later settle. Otherwise the output trit itself is reported as unresolved.

Internally the block scans both words from the most significant trit downwards. A two-trit comparison state records whether one word is already known to lead and the parity of the common prefix. Every transition and every output digit is built from three-valued AND, OR and NOT operations. Each of these operations gives the closure of its own Boolean function. The sorted words leave either directly or through one register stage chosen by a parameter.

Top module: `mc_gray_sorter`

## Requirements
- R1: A trit is carried on two wires as 2'b00 = stable 0, 2'b11 = stable 1, 2'b01 = unresolved. The code 2'b10 never appears on an input, and never appears on an output while the inputs are legal.
- R2: Trit k of a word occupies bits [2k+1:2k]. Trit WIDTH-1 is the most significant. Words are binary-reflected Gray codes.
- R3: When neither input holds an unresolved trit, `max_o` and `min_o` are the larger and smaller input, ordered by Gray-decoded value, and they hold no unresolved trit.
- R4: When each input holds at most one unresolved trit, every output trit is stable 0 or stable 1 exactly when all settlings of the unresolved inputs give that trit the same value in the sorted result. Otherwise it is unresolved.
- R5: When both inputs are the same word, both outputs equal that word.
- R6: At a trit position where both inputs carry the same stable value, both outputs carry that value.
- R7: Exchanging `a_i` and `b_i` leaves both outputs unchanged.
- R8: With REG_OUT=1 the outputs change only at a rising clock edge and show the result for the inputs sampled at that edge. With REG_OUT=0 they follow the inputs without a clock.
- R9: With REG_OUT=1, a low `rst_n` at a rising edge sets every output trit to stable 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a_i | input | 2*WIDTH | First Gray word, two wires per trit |
| b_i | input | 2*WIDTH | Second Gray word, two wires per trit |
| max_o | output | 2*WIDTH | Larger word under closure semantics |
| min_o | output | 2*WIDTH | Smaller word under closure semantics |

## Verification
The bench builds two copies at WIDTH=4, one with REG_OUT=1 and one with REG_OUT=0. At that width each input can take one of 48 words: 16 fully stable words and 32 words that each hold one unresolved trit. All 2304 ordered pairs can therefore be applied, so every swap, every pairing of unresolved positions (the same position or different ones) and every parity of the shared prefix is covered. Each output is compared with a closure computed by settling each unresolved trit both ways and taking the numeric maximum and minimum of the decoded values.

// File: rtl/mcgs_pkg.sv
// Shared types and three-valued gate functions for the Gray sorter.
// Assumes a trit is {surely_one, maybe_one}: 00 = 0, 11 = 1, 01 = unresolved.
// Each gate returns the closure of its Boolean function on that encoding.
package mcgs_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t TRIT_0 = 2'b00;
    localparam trit_t TRIT_1 = 2'b11;
    localparam trit_t TRIT_M = 2'b01;

    // Scan state: x_lead set alone = first word ahead, y_lead alone = second
    // word ahead, both clear = equal prefix with even parity, both set = odd.
    typedef struct packed {
        trit_t x_lead;
        trit_t y_lead;
    } scan_t;

    localparam scan_t SCAN_INIT = '{x_lead: TRIT_0, y_lead: TRIT_0};

    // Closure AND: surely-one and maybe-one both combine conjunctively.
    function automatic trit_t t_and(trit_t p, trit_t q);
        return p & q;
    endfunction

    // Closure OR: dual of closure AND.
    function automatic trit_t t_or(trit_t p, trit_t q);
        return p | q;
    endfunction

    // Closure NOT: swaps and inverts the two wires, so unresolved stays unresolved.
    function automatic trit_t t_not(trit_t p);
        return {~p[0], ~p[1]};
    endfunction

endpackage

// File: rtl/mcgs_step.sv
// One step of the MSB-first comparison scan.
// Consumes one trit from each word and advances the scan state.
// Equations are complete sums of prime implicants, so that three-valued
// evaluation gives the closure of the transition function.
module mcgs_step
    import mcgs_pkg::*;
(
    input  scan_t cur,
    input  trit_t x,
    input  trit_t y,
    output scan_t nxt
);

    trit_t not_a, not_b, not_x, not_y;

    // Advance: equal-even copies (x,y); equal-odd copies inverted; decided holds.
    always_comb begin : p_step
        not_a = t_not(cur.x_lead);
        not_b = t_not(cur.y_lead);
        not_x = t_not(x);
        not_y = t_not(y);
        nxt.x_lead = t_or(t_or(t_and(cur.x_lead, not_b), t_and(not_b, x)),
                          t_and(cur.x_lead, not_x));
        nxt.y_lead = t_or(t_or(t_and(cur.y_lead, not_a), t_and(not_a, y)),
                          t_and(cur.y_lead, not_y));
    end

endmodule

// File: rtl/mcgs_merge.sv
// Output digit selection for one trit position.
// From the scan state above this position, picks the max and min digit:
// equal-even gives OR/AND, equal-odd gives AND/OR, a decided state steers.
// Complete prime-implicant sums keep the result equal to the closure.
module mcgs_merge
    import mcgs_pkg::*;
(
    input  scan_t cur,
    input  trit_t x,
    input  trit_t y,
    output trit_t hi_t,
    output trit_t lo_t
);

    trit_t not_a, not_b, both;

    // Select the larger and smaller digit at this position.
    always_comb begin : p_merge
        not_a = t_not(cur.x_lead);
        not_b = t_not(cur.y_lead);
        both  = t_and(x, y);
        hi_t  = t_or(t_or(t_and(not_b, x), t_and(not_a, y)), both);
        lo_t  = t_or(t_or(t_and(cur.x_lead, y), t_and(cur.y_lead, x)), both);
    end

endmodule

// File: rtl/mcgs_chain.sv
// Ripple scan across all trits, most significant first.
// Assumes packed words with trit k at bits [2k+1:2k].
// The state after the last trit is not needed, so no step is built for it.
module mcgs_chain
    import mcgs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [2*WIDTH-1:0] x_w,
    input  logic [2*WIDTH-1:0] y_w,
    output logic [2*WIDTH-1:0] hi_w,
    output logic [2*WIDTH-1:0] lo_w
);

    localparam int TOP = WIDTH - 1;

    scan_t [WIDTH-1:0] scan_w;

    assign scan_w[TOP] = SCAN_INIT;

    for (genvar k = 0; k < WIDTH; k++) begin : g_pos
        mcgs_merge u_merge (
            .cur  (scan_w[k]),
            .x    (x_w[2*k +: 2]),
            .y    (y_w[2*k +: 2]),
            .hi_t (hi_w[2*k +: 2]),
            .lo_t (lo_w[2*k +: 2])
        );
        if (k > 0) begin : g_step
            mcgs_step u_step (
                .cur (scan_w[k]),
                .x   (x_w[2*k +: 2]),
                .y   (y_w[2*k +: 2]),
                .nxt (scan_w[k-1])
            );
        end
    end

endmodule

// File: rtl/mc_gray_sorter.sv
// Two-input sorter for Gray words of three-valued trits.
// Assumes at most one unresolved trit per input word; outputs follow the
// closure of max/min. REG_OUT selects a registered or combinational output.
module mc_gray_sorter
    import mcgs_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*WIDTH-1:0]   a_i,
    input  logic [2*WIDTH-1:0]   b_i,
    output logic [2*WIDTH-1:0]   max_o,
    output logic [2*WIDTH-1:0]   min_o
);

    localparam int WORD_BITS = 2 * WIDTH;

    logic [WORD_BITS-1:0] hi_w, lo_w;

    mcgs_chain #(.WIDTH(WIDTH)) u_chain (
        .x_w  (a_i),
        .y_w  (b_i),
        .hi_w (hi_w),
        .lo_w (lo_w)
    );

    if (REG_OUT) begin : g_reg
        // Capture the sorted pair; reset loads stable zeros.
        always_ff @(posedge clk) begin : p_out
            if (!rst_n) begin
                max_o <= '0;
                min_o <= '0;
            end else begin
                max_o <= hi_w;
                min_o <= lo_w;
            end
        end
    end else begin : g_comb
        assign max_o = hi_w;
        assign min_o = lo_w;
    end

endmodule

// File: rtl/mc_gray_sorter_chk.sv
// Property checker for the Gray sorter, bound into every instance.
// Keeps its own copy of the inputs so that registered outputs can be
// related to the inputs one edge earlier.
module mc_gray_sorter_chk
    import mcgs_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*WIDTH-1:0] a_i,
    input logic [2*WIDTH-1:0] b_i,
    input logic [2*WIDTH-1:0] max_o,
    input logic [2*WIDTH-1:0] min_o
);

    logic [2*WIDTH-1:0] a_d, b_d, a_ref, b_ref;

    function automatic logic has_code(logic [2*WIDTH-1:0] w, trit_t c);
        logic hit = 1'b0;
        for (int k = 0; k < WIDTH; k++) begin
            if (w[2*k +: 2] == c) hit = 1'b1;
        end
        return hit;
    endfunction

    // Input history, cleared to the value the output register resets to.
    always_ff @(posedge clk) begin : p_hist
        if (!rst_n) begin
            a_d <= '0;
            b_d <= '0;
        end else begin
            a_d <= a_i;
            b_d <= b_i;
        end
    end

    assign a_ref = REG_OUT ? a_d : a_i;
    assign b_ref = REG_OUT ? b_d : b_i;

    AST_IN_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !has_code(a_i, 2'b10) && !has_code(b_i, 2'b10)); // R1

    AST_OUT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !has_code(max_o, 2'b10) && !has_code(min_o, 2'b10)); // R1

    AST_STABLE_IN_STABLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_code(a_ref, TRIT_M) && !has_code(b_ref, TRIT_M))
        |-> (!has_code(max_o, TRIT_M) && !has_code(min_o, TRIT_M))); // R3

    AST_EQUAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ref == b_ref) |-> (max_o == a_ref && min_o == a_ref)); // R5

    for (genvar k = 0; k < WIDTH; k++) begin : g_agree
        AST_AGREE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (a_ref[2*k +: 2] == b_ref[2*k +: 2] && a_ref[2*k +: 2] != TRIT_M)
            |-> (max_o[2*k +: 2] == a_ref[2*k +: 2] && min_o[2*k +: 2] == a_ref[2*k +: 2])); // R6
    end

endmodule

bind mc_gray_sorter mc_gray_sorter_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (a_i),
    .b_i   (b_i),
    .max_o (max_o),
    .min_o (min_o)
);

// File: tb/mc_gray_sorter_tb.sv
`timescale 1ns/1ps
// Exhaustive bench: every pair of 4-trit words with at most one unresolved
// trit each, against a closure model that settles each unresolved trit both ways.
module mc_gray_sorter_tb;

    localparam int BW     = 4;
    localparam int WB     = 2 * BW;
    localparam int HALF   = 1 << (BW - 1);
    localparam int NWORDS = (1 << BW) + BW * HALF;
    localparam int MASK   = (1 << BW) - 1;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [WB-1:0] a_s   = '0;
    logic [WB-1:0] b_s   = '0;
    logic [WB-1:0] max_r, min_r, max_c, min_c;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    mc_gray_sorter #(.WIDTH(BW), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_i(a_s), .b_i(b_s), .max_o(max_r), .min_o(min_r)
    );

    mc_gray_sorter #(.WIDTH(BW), .REG_OUT(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .a_i(a_s), .b_i(b_s), .max_o(max_c), .min_o(min_c)
    );

    function automatic int gray2bin(int g);
        int b = 0;
        for (int s = g; s != 0; s = s >> 1) b = b ^ s;
        return b;
    endfunction

    // Index -> (value bits, unresolved mask); the unresolved bit's value is 0.
    function automatic void word_of(int idx, output int v, output int m);
        int j, pos, rest;
        if (idx < (1 << BW)) begin
            v = idx;
            m = 0;
        end else begin
            j    = idx - (1 << BW);
            pos  = j / HALF;
            rest = j % HALF;
            v    = ((rest >> pos) << (pos + 1)) | (rest & ((1 << pos) - 1));
            m    = 1 << pos;
        end
    endfunction

    // R1 R2: trit k at bits [2k+1:2k], 00/11/01 encoding.
    function automatic logic [WB-1:0] encode(int v, int m);
        logic [WB-1:0] w;
        for (int k = 0; k < BW; k++) begin
            if (m[k])      w[2*k +: 2] = 2'b01;
            else if (v[k]) w[2*k +: 2] = 2'b11;
            else           w[2*k +: 2] = 2'b00;
        end
        return w;
    endfunction

    // Closure of max/min over all settlings of the unresolved trits.
    function automatic void closure(int va, int ma, int vb, int mb,
                                    output logic [WB-1:0] emax, output logic [WB-1:0] emin);
        int s1x, s0x, s1n, s0n, ga, gb, hi, lo;
        s1x = 0; s0x = 0; s1n = 0; s0n = 0;
        for (int ra = 0; ra < 2; ra++) begin
            for (int rb = 0; rb < 2; rb++) begin
                if (!((ma == 0 && ra == 1) || (mb == 0 && rb == 1))) begin
                    ga = ra ? (va | ma) : va;
                    gb = rb ? (vb | mb) : vb;
                    if (gray2bin(ga) >= gray2bin(gb)) begin
                        hi = ga; lo = gb;
                    end else begin
                        hi = gb; lo = ga;
                    end
                    s1x = s1x | hi;
                    s0x = s0x | (~hi & MASK);
                    s1n = s1n | lo;
                    s0n = s0n | (~lo & MASK);
                end
            end
        end
        for (int k = 0; k < BW; k++) begin
            emax[2*k +: 2] = (s1x[k] && s0x[k]) ? 2'b01 : (s1x[k] ? 2'b11 : 2'b00);
            emin[2*k +: 2] = (s1n[k] && s0n[k]) ? 2'b01 : (s1n[k] ? 2'b11 : 2'b00);
        end
    endfunction

    task automatic chk(input logic [2*WB-1:0] act, input logic [2*WB-1:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h got {max,min}=%h expected %h", tag, a_s, b_s, act, exp);
        end
    endtask

    initial begin : p_watchdog
        #(200000 * 5.0);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion expected completion within 200000 cycles");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : p_main
        logic [WB-1:0] emax, emin, pmax, pmin;
        logic [WB-1:0] wa, wb;
        int  va, ma, vb, mb;
        bit  have_prev;
        bit  agree_any, agree_ok;
        string tag;

        // R9: reset clears registered outputs even with busy inputs.
        a_s = {BW{2'b01}};
        b_s = {BW{2'b11}};
        repeat (3) begin
            @(negedge clk);
            chk({max_r, min_r}, '0, "R9 reset clears outputs");
        end

        have_prev = 1'b0;
        pmax = '0;
        pmin = '0;
        for (int i = 0; i < NWORDS; i++) begin
            for (int j = 0; j < NWORDS; j++) begin
                @(negedge clk);
                // R8: registered copy shows the previous pair one edge later.
                if (have_prev) chk({max_r, min_r}, {pmax, pmin}, "R8 one-edge latency");
                word_of(i, va, ma);
                word_of(j, vb, mb);
                wa = encode(va, ma);
                wb = encode(vb, mb);
                rst_n = 1'b1;
                a_s = wa;
                b_s = wb;
                closure(va, ma, vb, mb, emax, emin);
                #1;
                // R8: registered copy has not moved before the edge.
                if (have_prev) chk({max_r, min_r}, {pmax, pmin}, "R8 holds between edges");
                if (ma == 0 && mb == 0) tag = "R3 stable sort R7";
                else                    tag = "R4 closure R7";
                if (wa == wb) tag = {tag, " R5 equal words"};
                chk({max_c, min_c}, {emax, emin}, tag);
                // R6: agreeing stable trits pass through on both outputs.
                agree_any = 1'b0;
                agree_ok  = 1'b1;
                for (int k = 0; k < BW; k++) begin
                    if (wa[2*k +: 2] == wb[2*k +: 2] && wa[2*k +: 2] != 2'b01) begin
                        agree_any = 1'b1;
                        if (max_c[2*k +: 2] !== wa[2*k +: 2] || min_c[2*k +: 2] !== wa[2*k +: 2])
                            agree_ok = 1'b0;
                    end
                end
                if (agree_any) chk({max_c, min_c}, agree_ok ? {max_c, min_c} : ~{max_c, min_c},
                                   "R6 agreeing trit kept");
                pmax = emax;
                pmin = emin;
                have_prev = 1'b1;
            end
        end
        @(negedge clk);
        chk({max_r, min_r}, {pmax, pmin}, "R8 final pair");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule